// File: doc/BRIEF.md
# Cross-Clock Video Memory Write Queue

This block lets a processor running on its own slow clock post writes into a video memory owned by a renderer on a separate pixel clock. The processor first loads a 16-bit target address register and a 16-bit write-data register. It then writes the control register, which pushes the pair as one 32-bit entry into a 16-deep asynchronous queue. The processor is never stalled. Instead it can read the control register to learn whether the queue is full, and whether a push was lost since its last look.

On the pixel-clock side, the oldest entry is split back into an address and a data word. It is presented as a single-cycle video memory write, but only in a pixel cycle where the renderer has said it is not using the memory port. Entries leave in the order they were pushed, at most one per free cycle.

The two pointers cross between the clock domains in Gray code through two-flop synchronizers. Each clock domain has its own asynchronous reset, which is released synchronously to that clock.

Top module: `vram_post_queue`

## Requirements
- R1: After reset, `vram_we` is low and a read of the control register returns 0.
- R2: The register select `cpu_reg` encodes address=0, data=1, control=2. A write to the control register pushes the entry {address register in bits 31:16, data register in bits 15:0}. The value written to the control register itself is ignored.
- R3: Control read bit 0 is 1 while 16 pushed entries are still waiting, and 0 while fewer are waiting. It returns to 0 once the queue drains.
- R4: A push made while the queue is full is discarded. It leaves the queue contents unchanged and sets a sticky overflow flag, which reads as control bit 1.
- R5: A read of the control register clears the overflow flag from the next cycle on.
- R6: No video memory write is issued in a pixel cycle where `rend_busy` is high.
- R7: Every accepted entry appears exactly once on the video memory port, in push order, with one entry per pixel cycle in which the queue is non-empty and the renderer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor clock |
| cpu_rst_n | input | 1 | Processor-domain asynchronous reset, active low |
| cpu_sel | input | 1 | Register access strobe, one access per cycle |
| cpu_we | input | 1 | 1 = write access, 0 = read access |
| cpu_reg | input | 2 | Register select: 0 address, 1 data, 2 control |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data; control gives {14'b0, overflow, full}, others 0 |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Pixel-domain asynchronous reset, active low |
| rend_busy | input | 1 | Renderer owns the memory port this cycle |
| vram_we | output | 1 | Video memory write enable |
| vram_addr | output | 16 | Video memory write address |
| vram_wdata | output | 16 | Video memory write data |

## Verification
Register writes take effect at the processor edge that ends the access. The full flag is visible on the next read because it is computed from the local write pointer. The overflow flag sets one edge after a rejected push and clears one edge after a control read. The bench reads the control register only after those edges, sampling at the falling clock edge.

A new entry reaches the video port no sooner than three pixel edges after its push, because of the two synchronizer stages plus the empty register. The video port is combinational within the pixel cycle, so the bench logs a write at each pixel falling edge where `vram_we` is high. The bench waits many cycles of both clocks before comparing the log with the expected order. It compares with a log snapshot while the renderer is held busy.

// File: rtl/vpq_pkg.sv
`timescale 1ns/1ps
package vpq_pkg;
  localparam int unsigned VPQ_AW = 16;
  localparam int unsigned VPQ_DW = 16;
  localparam int unsigned VPQ_EW = VPQ_AW + VPQ_DW;

  typedef enum logic [1:0] {
    REG_ADDR = 2'd0,
    REG_DATA = 2'd1,
    REG_CTRL = 2'd2,
    REG_NONE = 2'd3
  } vpq_reg_e;
endpackage

// File: rtl/vpq_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous release.
module vpq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/vpq_ptr_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer for a Gray-coded pointer.
module vpq_ptr_sync #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] m_q, o_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '0;
      o_q <= '0;
    end else begin
      m_q <= d;
      o_q <= m_q;
    end
  end

  assign q = o_q;
endmodule

// File: rtl/vpq_wr_ctl.sv
`timescale 1ns/1ps
// Write-side pointer, full flag and sticky overflow flag (processor clock).
module vpq_wr_ctl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enq_req,
  input  logic          ctrl_rd,
  input  logic [AW:0]   rgray_sync,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          push,
  output logic          ovf
);
  logic [AW:0] wbin_q, wbin_d, wgray_q, wgray_d, full_pat;
  logic        full_q, full_d, ovf_q, ovf_d;

  assign push     = enq_req & ~full_q;
  assign full_pat = {~rgray_sync[AW:AW-1], rgray_sync[AW-2:0]};

  always_comb begin
    wbin_d  = wbin_q + {{AW{1'b0}}, push};
    wgray_d = wbin_d ^ (wbin_d >> 1);
    full_d  = (wgray_d == full_pat);
    ovf_d   = ovf_q;
    if (ctrl_rd)            ovf_d = 1'b0;
    if (enq_req && full_q)  ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      full_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= wgray_d;
      full_q  <= full_d;
      ovf_q   <= ovf_d;
    end
  end

  assign waddr = wbin_q[AW-1:0];
  assign wgray = wgray_q;
  assign full  = full_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/vpq_rd_ctl.sv
`timescale 1ns/1ps
// Read-side pointer and empty flag (pixel clock); pops only in free slots.
module vpq_rd_ctl #(
  parameter int unsigned AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_free,
  input  logic [AW:0]   wgray_sync,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          pop
);
  logic [AW:0] rbin_q, rbin_d, rgray_q, rgray_d;
  logic        empty_q, empty_d;

  assign pop = ~empty_q & slot_free;

  always_comb begin
    rbin_d  = rbin_q + {{AW{1'b0}}, pop};
    rgray_d = rbin_d ^ (rbin_d >> 1);
    empty_d = (rgray_d == wgray_sync);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      empty_q <= 1'b1;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= rgray_d;
      empty_q <= empty_d;
    end
  end

  assign raddr = rbin_q[AW-1:0];
  assign rgray = rgray_q;
endmodule

// File: rtl/vram_post_queue.sv
`timescale 1ns/1ps
module vram_post_queue #(
  parameter int unsigned DEPTH = 16
) (
  input  logic        cpu_clk,
  input  logic        cpu_rst_n,
  input  logic        cpu_sel,
  input  logic        cpu_we,
  input  logic [1:0]  cpu_reg,
  input  logic [15:0] cpu_wdata,
  output logic [15:0] cpu_rdata,
  input  logic        pix_clk,
  input  logic        pix_rst_n,
  input  logic        rend_busy,
  output logic        vram_we,
  output logic [15:0] vram_addr,
  output logic [15:0] vram_wdata
);
  import vpq_pkg::*;

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic cpu_rst_s_n, pix_rst_s_n;

  vpq_rst_sync u_cpu_rst (.clk(cpu_clk), .arst_n(cpu_rst_n), .srst_n(cpu_rst_s_n));
  vpq_rst_sync u_pix_rst (.clk(pix_clk), .arst_n(pix_rst_n), .srst_n(pix_rst_s_n));

  // Processor-side register file
  logic [VPQ_AW-1:0] addr_q;
  logic [VPQ_DW-1:0] data_q;
  logic              addr_en, data_en, enq_req, ctrl_rd;

  assign addr_en = cpu_sel & cpu_we & (cpu_reg == REG_ADDR);
  assign data_en = cpu_sel & cpu_we & (cpu_reg == REG_DATA);
  assign enq_req = cpu_sel & cpu_we & (cpu_reg == REG_CTRL);
  assign ctrl_rd = cpu_sel & ~cpu_we & (cpu_reg == REG_CTRL);

  always_ff @(posedge cpu_clk or negedge cpu_rst_s_n) begin
    if (!cpu_rst_s_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (addr_en) addr_q <= cpu_wdata;
      if (data_en) data_q <= cpu_wdata;
    end
  end

  // Queue control
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_pix, rgray_cpu;
  logic          wr_full, push, ovf, pop;

  vpq_wr_ctl #(.AW(AW)) u_wr (
    .clk(cpu_clk), .rst_n(cpu_rst_s_n), .enq_req(enq_req), .ctrl_rd(ctrl_rd),
    .rgray_sync(rgray_cpu), .waddr(waddr), .wgray(wgray), .full(wr_full),
    .push(push), .ovf(ovf)
  );

  vpq_ptr_sync #(.W(PW)) u_r2w (.clk(cpu_clk), .rst_n(cpu_rst_s_n), .d(rgray), .q(rgray_cpu));
  vpq_ptr_sync #(.W(PW)) u_w2r (.clk(pix_clk), .rst_n(pix_rst_s_n), .d(wgray), .q(wgray_pix));

  vpq_rd_ctl #(.AW(AW)) u_rd (
    .clk(pix_clk), .rst_n(pix_rst_s_n), .slot_free(~rend_busy),
    .wgray_sync(wgray_pix), .raddr(raddr), .rgray(rgray), .pop(pop)
  );

  // Entry storage: written on the processor clock, read on the pixel clock
  logic [VPQ_EW-1:0] store_q [DEPTH];

  always_ff @(posedge cpu_clk) begin
    if (push) store_q[waddr] <= {addr_q, data_q};
  end

  assign vram_we                 = pop;
  assign {vram_addr, vram_wdata} = store_q[raddr];

  always_comb begin
    cpu_rdata = '0;
    if (ctrl_rd) cpu_rdata = {14'd0, ovf, wr_full};
  end
endmodule

// File: rtl/vpq_checker.sv
`timescale 1ns/1ps
module vpq_checker #(
  parameter int unsigned PW = 5
) (
  input logic          cpu_clk,
  input logic          cpu_rst_s_n,
  input logic          pix_clk,
  input logic          pix_rst_s_n,
  input logic          enq_req,
  input logic          ctrl_rd,
  input logic          wr_full,
  input logic          ovf,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic          rend_busy,
  input logic          vram_we
);
  assert_drop_sets_ovf_R4: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_s_n)
    (enq_req && wr_full) |=> ovf);

  assert_drop_holds_ptr_R4: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_s_n)
    (enq_req && wr_full) |=> $stable(wgray));

  assert_read_clears_ovf_R5: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_s_n)
    ctrl_rd |=> !ovf);

  assert_busy_blocks_write_R6: assert property (@(posedge pix_clk) disable iff (!pix_rst_s_n)
    rend_busy |-> !vram_we);

  assert_wgray_step_R7: assert property (@(posedge cpu_clk) disable iff (!cpu_rst_s_n)
    $countones(wgray ^ $past(wgray)) <= 1);

  assert_rgray_step_R7: assert property (@(posedge pix_clk) disable iff (!pix_rst_s_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind vram_post_queue vpq_checker #(.PW(PW)) u_chk (
  .cpu_clk(cpu_clk), .cpu_rst_s_n(cpu_rst_s_n), .pix_clk(pix_clk),
  .pix_rst_s_n(pix_rst_s_n), .enq_req(enq_req), .ctrl_rd(ctrl_rd),
  .wr_full(wr_full), .ovf(ovf), .wgray(wgray), .rgray(rgray),
  .rend_busy(rend_busy), .vram_we(vram_we)
);

// File: tb/tb_vram_post_queue.sv
`timescale 1ns/1ps
module tb_vram_post_queue;
  logic        cpu_clk = 1'b0, pix_clk = 1'b0;
  logic        cpu_rst_n = 1'b0, pix_rst_n = 1'b0;
  logic        cpu_sel = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_reg = 2'd3;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        rend_busy = 1'b0;
  logic        vram_we;
  logic [15:0] vram_addr, vram_wdata;

  always #10 cpu_clk = ~cpu_clk;   // 50 MHz processor side
  always #6.5 pix_clk = ~pix_clk;  // unrelated pixel clock

  vram_post_queue dut (.*);

  int n_chk = 0, n_fail = 0, n_log = 0, busy_viol = 0;
  int busy_mode = 0;
  bit done = 1'b0;
  logic [31:0] log_q [64];

  localparam logic [31:0] VEC [8] = '{
    32'h0000_1234, 32'hFFFF_0001, 32'h8000_A5A5, 32'h0001_FFFF,
    32'h7FFE_0000, 32'h1357_2468, 32'hAAAA_5555, 32'h0F0F_F0F0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] r, input logic [15:0] v);
    @(negedge cpu_clk);
    cpu_sel = 1'b1; cpu_we = 1'b1; cpu_reg = r; cpu_wdata = v;
    @(negedge cpu_clk);
    cpu_sel = 1'b0; cpu_we = 1'b0; cpu_reg = 2'd3;
  endtask

  task automatic post(input logic [31:0] e);
    reg_wr(2'd0, e[31:16]);
    reg_wr(2'd1, e[15:0]);
    reg_wr(2'd2, 16'hFFFF);  // value on control write must be ignored (R2)
  endtask

  task automatic ctrl_read(output logic [15:0] v);
    @(negedge cpu_clk);
    cpu_sel = 1'b1; cpu_we = 1'b0; cpu_reg = 2'd2;
    #1 v = cpu_rdata;
    @(negedge cpu_clk);
    cpu_sel = 1'b0; cpu_reg = 2'd3;
  endtask

  function automatic logic [31:0] gen(input int i);
    return {16'h4000 + 16'(i * 3), 16'hC300 ^ 16'(i * 17)};
  endfunction

  // Renderer busy driver, changed just after each pixel edge
  int pcnt = 0;
  initial forever begin
    @(posedge pix_clk);
    #1;
    pcnt++;
    rend_busy = (busy_mode == 2) ? 1'b1 : (busy_mode == 1) ? ((pcnt % 3) == 0) : 1'b0;
  end

  // Memory model: log writes at the pixel falling edge
  initial forever begin
    @(negedge pix_clk);
    if (vram_we) begin
      if (rend_busy) busy_viol++;
      if (n_log < 64) log_q[n_log] = {vram_addr, vram_wdata};
      n_log++;
    end
  end

  initial begin
    repeat (20000) @(posedge cpu_clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  logic [15:0] rv;
  int base;
  initial begin
    repeat (3) @(negedge cpu_clk);
    cpu_rst_n = 1'b1; pix_rst_n = 1'b1;
    repeat (4) @(negedge cpu_clk);

    // R1 reset state
    check("R1 vram_we", {31'd0, vram_we}, 32'd0);
    ctrl_read(rv);
    check("R1 ctrl", {16'd0, rv}, 32'd0);

    // Table walk, renderer toggling busy
    busy_mode = 1;
    for (int i = 0; i < 8; i++) post(VEC[i]);
    repeat (60) @(negedge cpu_clk);
    check("R7 count", n_log, 8);
    for (int i = 0; i < 8; i++) check("R2/R7 entry", log_q[i], VEC[i]);
    check("R6 busy cycles", busy_viol, 0);

    // Fill to full with renderer held busy
    busy_mode = 2;
    repeat (4) @(negedge cpu_clk);
    base = n_log;
    for (int i = 0; i < 15; i++) post(gen(i));
    ctrl_read(rv);
    check("R3 fifteen waiting", {16'd0, rv}, 32'd0);
    post(gen(15));
    ctrl_read(rv);
    check("R3 full", {16'd0, rv}, 32'd1);
    post(32'hDEAD_BEEF);
    ctrl_read(rv);
    check("R4 overflow", {16'd0, rv}, 32'd3);
    ctrl_read(rv);
    check("R5 cleared", {16'd0, rv}, 32'd1);
    check("R6 held busy", n_log, base);

    // Release and drain
    busy_mode = 0;
    repeat (80) @(negedge cpu_clk);
    check("R4/R7 count", n_log, base + 16);
    for (int i = 0; i < 16; i++) check("R7 order", log_q[base + i], gen(i));
    ctrl_read(rv);
    check("R3 drained", {16'd0, rv}, 32'd0);
    check("R6 busy cycles", busy_viol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule